// File: doc/BRIEF.md
# Serial Block Read-Back Verifier

This block checks a block of bytes held in a target device against an expected copy. It talks to the device over a two-wire link: a clock line it always drives, and a bidirectional data line with its own output-enable. After one pulse on `start_i`, it reads the bytes at addresses 0, 1, 2 and onward, one serial read per byte. Each read follows a fixed pattern of bit slots. A read-command prefix goes out first. The byte's address follows, then two turnaround slots. Next the block lets go of the data line and receives eight data bits, waits one idle slot, and drives a single closing bit.

As each read closes, the received byte is compared with the expected byte. The expected byte comes from an external buffer, which the block addresses through `exp_idx_o`. The first mismatch ends the run on the spot: the block records the failing index and the received byte, stops the clock and leaves the data line released. If every byte matches, the run ends with a pass. In both cases a one-cycle done pulse marks the end.

The link runs at a fixed fraction of the system clock. Every bit slot is `HALF_DIV` system cycles with SCLK low followed by `HALF_DIV` cycles with SCLK high. Driven data changes at the start of a slot, while SCLK is low, so the target sees it settled at the rising edge. Target data is taken in on the rising edge.

Top module: `blk_readback_verify`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, fail_o, sclk_o, sdata_o and sdata_oe_o are all 0.
- R2: Each bit slot lasts 2*HALF_DIV cycles, with SCLK low for the first HALF_DIV and high for the rest (with the defaults, 2 low and 2 high). sdata_o and sdata_oe_o change only at a slot start and hold through the high phase.
- R3: Each read opens with PFX_BITS driven slots carrying PFX_CODE, most significant bit first (default 4'b1011).
- R4: Next come ADDR_BITS driven slots carrying the byte index, most significant bit first, starting from index 0. Internally the address is kept left-justified in 8 bits, so it steps by 2^(8-ADDR_BITS) per byte (2 for the default of 7 bits).
- R5: After the address, two more driven slots carry 0. sdata_oe_o then falls while SCLK is low and stays 0 for eight receive slots and one idle slot. Received bits are taken on the rising SCLK edge, most significant bit first. sdata_o is 0 whenever sdata_oe_o is 0.
- R6: Each read closes with one driven slot carrying END_BIT (default 1).
- R7: When a read closes, the received byte is compared with exp_data_i for index exp_idx_o. On a mismatch the run stops at once: fail_o=1, fail_idx_o=index, fail_byte_o=received byte, and there is no further SCLK activity or data drive.
- R8: If all NUM_BYTES bytes match, pass_o=1 and fail_o=0. pass_o and fail_o are never 1 together.
- R9: A mismatch on the last byte (index NUM_BYTES-1) reports fail with that index, not pass.
- R10: done_o is a one-cycle pulse in the cycle after the last slot, and busy_o falls in that same cycle. pass_o, fail_o, fail_idx_o and fail_byte_o hold until the next accepted start, which clears pass_o and fail_o.
- R11: A start_i pulse while busy_o=1 has no effect on the link waveform or on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a read-back run when idle |
| exp_idx_o | output | IDXW | Index of the byte now being read, addressing the expected buffer |
| exp_data_i | input | 8 | Expected byte for exp_idx_o |
| sclk_o | output | 1 | Link clock to the target |
| sdata_o | output | 1 | Data driven to the target |
| sdata_oe_o | output | 1 | Output enable for the data line |
| sdata_i | input | 1 | Data line as seen from the target side |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Every byte matched |
| fail_o | output | 1 | A byte mismatched |
| fail_idx_o | output | IDXW | Index of the mismatching byte |
| fail_byte_o | output | 8 | Byte received at the mismatching index |

## Verification
Two things can happen on the same edge: the comparison of the final byte and the natural end of the loop. Both close the run in one cycle. The bench provokes the collision by corrupting only the last byte of the target image. The run must then raise fail with index NUM_BYTES-1 and the corrupted byte, and pass must stay low. The same edge is also seen with a clean image, where it must yield pass. This rules out a design that gives loop exhaustion priority over the mismatch.

// File: rtl/rbv_pkg.sv
package rbv_pkg;

  // Bit-slot groups of one serial read, in wire order.
  typedef enum logic [2:0] {
    F_PFX  = 3'd0,
    F_ADR  = 3'd1,
    F_GAP  = 3'd2,
    F_RX   = 3'd3,
    F_TAIL = 3'd4,
    F_END  = 3'd5
  } rbv_field_e;

  localparam int unsigned GAP_SLOTS  = 2;
  localparam int unsigned RX_SLOTS   = 8;
  localparam int unsigned TAIL_SLOTS = 1;
  localparam int unsigned END_SLOTS  = 1;

  // Number of bit slots in a group.
  function automatic int unsigned field_len(rbv_field_e f, int unsigned pfx_bits,
                                            int unsigned addr_bits);
    case (f)
      F_PFX:   return pfx_bits;
      F_ADR:   return addr_bits;
      F_GAP:   return GAP_SLOTS;
      F_RX:    return RX_SLOTS;
      F_TAIL:  return TAIL_SLOTS;
      default: return END_SLOTS;
    endcase
  endfunction

  // Group that follows a finished group; the closing bit wraps to the prefix.
  function automatic rbv_field_e next_field(rbv_field_e f);
    case (f)
      F_PFX:   return F_ADR;
      F_ADR:   return F_GAP;
      F_GAP:   return F_RX;
      F_RX:    return F_TAIL;
      F_TAIL:  return F_END;
      default: return F_PFX;
    endcase
  endfunction

  // True for groups during which the block owns the data line.
  function automatic logic field_drives(rbv_field_e f);
    return (f != F_RX) && (f != F_TAIL);
  endfunction

  // Increment of the left-justified 8-bit address register per byte.
  function automatic logic [7:0] addr_step(int unsigned addr_bits);
    return 8'(1 << (8 - addr_bits));
  endfunction

endpackage

// File: rtl/rbv_clkgen.sv
module rbv_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_stb,
  output logic slot_end
);
  localparam int unsigned PER = 2 * HALF_DIV;
  localparam int unsigned CW  = (PER > 2) ? $clog2(PER) : 1;

  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      div_q <= '0;
    else if (!run)                   div_q <= '0;
    else if (div_q == CW'(PER - 1))  div_q <= '0;
    else                             div_q <= div_q + CW'(1);
  end

  assign sclk     = run && (div_q >= CW'(HALF_DIV));
  assign rise_stb = run && (div_q == CW'(HALF_DIV - 1));
  assign slot_end = run && (div_q == CW'(PER - 1));

  AST_SCLK_RISES_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> sclk); // R2
  AST_SCLK_LOW_AT_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> !sclk); // R2

endmodule

// File: rtl/rbv_seq.sv
module rbv_seq
  import rbv_pkg::*;
#(
  parameter int unsigned             PFX_BITS  = 4,
  parameter logic [PFX_BITS-1:0]     PFX_CODE  = 4'b1011,
  parameter int unsigned             ADDR_BITS = 7,
  parameter logic                    END_BIT   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       load,
  input  logic       slot_end,
  input  logic [7:0] addr,
  output logic       last_slot,
  output logic       tx_bit,
  output logic       tx_oe,
  output logic       rx_cap_en
);
  localparam int unsigned L01  = (PFX_BITS > ADDR_BITS) ? PFX_BITS : ADDR_BITS;
  localparam int unsigned MAXL = (L01 > RX_SLOTS) ? L01 : RX_SLOTS;
  localparam int unsigned BW   = $clog2(MAXL + 1);

  rbv_field_e    field_q;
  logic [BW-1:0] bit_q;
  int unsigned   cur_len;
  logic          field_end;
  logic [PFX_BITS-1:0] pfx_sh;
  logic [7:0]    adr_sh;

  assign cur_len   = field_len(field_q, PFX_BITS, ADDR_BITS);
  assign field_end = slot_end && (bit_q == BW'(cur_len - 1));
  assign last_slot = field_end && (field_q == F_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= F_PFX;
      bit_q   <= '0;
    end else if (load) begin
      field_q <= F_PFX;
      bit_q   <= '0;
    end else if (field_end) begin
      field_q <= next_field(field_q);
      bit_q   <= '0;
    end else if (slot_end) begin
      bit_q   <= bit_q + BW'(1);
    end
  end

  // MSB-first selection by shifting rather than variable part-selects.
  assign pfx_sh = PFX_CODE >> (BW'(PFX_BITS - 1) - bit_q);
  assign adr_sh = addr << bit_q;

  always_comb begin
    case (field_q)
      F_PFX:   tx_bit = pfx_sh[0];
      F_ADR:   tx_bit = adr_sh[7];
      F_END:   tx_bit = END_BIT;
      default: tx_bit = 1'b0;
    endcase
  end

  assign tx_oe     = run && field_drives(field_q);
  assign rx_cap_en = run && (field_q == F_RX);

  AST_RX_FOLLOWS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(field_q) == F_GAP && field_q != F_GAP) |-> field_q == F_RX); // R5
  AST_PFX_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && $past(field_q) == F_END && field_q != F_END) |-> field_q == F_PFX); // R6

endmodule

// File: rtl/rbv_rxshift.sv
module rbv_rxshift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       cap,
  input  logic       din,
  output logic [7:0] byte_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     byte_o <= '0;
    else if (clear) byte_o <= '0;
    else if (cap)   byte_o <= {byte_o[6:0], din};
  end

  AST_RX_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !clear) |=> (byte_o[0] == $past(din)) && (byte_o[7:1] == $past(byte_o[6:0]))); // R5

endmodule

// File: rtl/blk_readback_verify.sv
module blk_readback_verify
  import rbv_pkg::*;
#(
  parameter int unsigned         NUM_BYTES = 128,
  parameter int unsigned         ADDR_BITS = 7,
  parameter int unsigned         PFX_BITS  = 4,
  parameter logic [PFX_BITS-1:0] PFX_CODE  = 4'b1011,
  parameter logic                END_BIT   = 1'b1,
  parameter int unsigned         HALF_DIV  = 2,
  localparam int unsigned        IDXW      = $clog2(NUM_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic [IDXW-1:0] exp_idx_o,
  input  logic [7:0]      exp_data_i,
  output logic            sclk_o,
  output logic            sdata_o,
  output logic            sdata_oe_o,
  input  logic            sdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            pass_o,
  output logic            fail_o,
  output logic [IDXW-1:0] fail_idx_o,
  output logic [7:0]      fail_byte_o
);
  localparam logic [7:0] STEP = addr_step(ADDR_BITS);

  logic            run_q, done_q, pass_q, fail_q;
  logic [IDXW-1:0] idx_q, fidx_q;
  logic [7:0]      addr_q, fbyte_q;

  // Named internal events.
  logic load, rise_stb, slot_end, last_slot;
  logic tx_bit, tx_oe, rx_cap_en;
  logic byte_done, byte_ok, last_idx, byte_adv;
  logic [7:0] rx_byte;

  assign load      = start_i && !run_q;
  assign byte_done = run_q && last_slot;
  assign byte_ok   = (rx_byte == exp_data_i);
  assign last_idx  = (idx_q == IDXW'(NUM_BYTES - 1));
  assign byte_adv  = byte_done && byte_ok && !last_idx;

  rbv_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .sclk     (sclk_o),
    .rise_stb (rise_stb),
    .slot_end (slot_end)
  );

  rbv_seq #(
    .PFX_BITS  (PFX_BITS),
    .PFX_CODE  (PFX_CODE),
    .ADDR_BITS (ADDR_BITS),
    .END_BIT   (END_BIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .load      (load),
    .slot_end  (slot_end),
    .addr      (addr_q),
    .last_slot (last_slot),
    .tx_bit    (tx_bit),
    .tx_oe     (tx_oe),
    .rx_cap_en (rx_cap_en)
  );

  rbv_rxshift u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (load),
    .cap    (rx_cap_en && rise_stb),
    .din    (sdata_i),
    .byte_o (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      idx_q   <= '0;
      addr_q  <= '0;
      fidx_q  <= '0;
      fbyte_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        run_q  <= 1'b1;
        idx_q  <= '0;
        addr_q <= '0;
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end else if (byte_done) begin
        if (!byte_ok) begin
          run_q   <= 1'b0;
          fail_q  <= 1'b1;
          fidx_q  <= idx_q;
          fbyte_q <= rx_byte;
          done_q  <= 1'b1;
        end else if (last_idx) begin
          run_q  <= 1'b0;
          pass_q <= 1'b1;
          done_q <= 1'b1;
        end else begin
          idx_q  <= idx_q + IDXW'(1);
          addr_q <= addr_q + STEP;
        end
      end
    end
  end

  assign exp_idx_o   = idx_q;
  assign sdata_oe_o  = tx_oe;
  assign sdata_o     = tx_oe & tx_bit;
  assign busy_o      = run_q;
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;
  assign fail_idx_o  = fidx_q;
  assign fail_byte_o = fbyte_q;

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> ($stable(sdata_o) && $stable(sdata_oe_o))); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_adv |=> (addr_q == $past(addr_q) + STEP)); // R4
  AST_TURN_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sdata_oe_o) && run_q) |-> !sclk_o); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!sclk_o && !sdata_oe_o && !sdata_o)); // R7
  AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start_i && !byte_done) |=> run_q); // R11

endmodule

// File: tb/sim_blk_readback_verify.sv
`timescale 1ns/1ps
module sim_blk_readback_verify;
  localparam int NB   = 128;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sdata_i = 1'b1;
  logic [6:0] exp_idx_o, fail_idx_o;
  logic [7:0] exp_data_i, fail_byte_o;
  logic sclk_o, sdata_o, sdata_oe_o, busy_o, done_o, pass_o, fail_o;

  logic [7:0] expb [NB];
  logic [7:0] tgt  [NB];

  int tests = 0;
  int fails = 0;

  bit    q_sclk[$];
  bit    q_oe[$];
  bit    q_sd[$];
  bit    q_drv[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  assign exp_data_i = expb[exp_idx_o];

  blk_readback_verify u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .exp_idx_o(exp_idx_o), .exp_data_i(exp_data_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .sdata_i(sdata_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .fail_idx_o(fail_idx_o), .fail_byte_o(fail_byte_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // One bit slot of the reference waveform: HALF cycles low, HALF high.
  task automatic push_slot(bit oe, bit d, bit drv, string tag);
    for (int c = 0; c < 2 * HALF; c++) begin
      q_sclk.push_back(c >= HALF);
      q_oe.push_back(oe);
      q_sd.push_back(oe & d);
      q_drv.push_back(drv);
      q_tag.push_back(tag);
    end
  endtask

  // bad < 0: clean image. poke: cycle at which a stray start is raised.
  task automatic run_case(int bad, logic [7:0] flip, int poke);
    int last_bad;
    logic [3:0] pf;
    logic [6:0] a;
    last_bad = -1;
    pf = 4'b1011;
    for (int i = 0; i < NB; i++) begin
      expb[i] = 8'((i * 73 + 29) ^ (i >> 2));
      tgt[i]  = expb[i];
    end
    if (bad >= 0) tgt[bad] = tgt[bad] ^ flip;
    q_sclk.delete(); q_oe.delete(); q_sd.delete(); q_drv.delete(); q_tag.delete();
    for (int k = 0; k < NB; k++) begin
      a = 7'(k);
      for (int b = 3; b >= 0; b--) push_slot(1'b1, pf[b], 1'b1, "R3");
      for (int b = 6; b >= 0; b--) push_slot(1'b1, a[b], 1'b1, "R4");
      push_slot(1'b1, 1'b0, 1'b1, "R5");
      push_slot(1'b1, 1'b0, 1'b1, "R5");
      for (int b = 7; b >= 0; b--) push_slot(1'b0, 1'b0, tgt[k][b], "R5");
      push_slot(1'b0, 1'b0, 1'b1, "R5");
      push_slot(1'b1, 1'b1, 1'b1, "R6");
      if (tgt[k] != expb[k]) begin
        last_bad = k;
        break;
      end
    end

    @(negedge clk) start_i = 1'b1;
    @(negedge clk);
    chk("R10", "pass cleared by start", {31'd0, pass_o}, 32'd0);
    chk("R10", "fail cleared by start", {31'd0, fail_o}, 32'd0);
    for (int n = 0; q_sclk.size() > 0; n++) begin
      chk("R2", $sformatf("sclk cyc %0d", n), {31'd0, sclk_o}, {31'd0, q_sclk[0]});
      chk(q_tag[0], $sformatf("oe/data cyc %0d", n), {30'd0, sdata_oe_o, sdata_o},
          {30'd0, q_oe[0], q_sd[0]});
      if (n % 1024 == 0) chk("R10", "busy during run", {31'd0, busy_o}, 32'd1);
      sdata_i = q_drv[0];
      start_i = (n == poke) ? 1'b1 : 1'b0;   // R11 stray start while busy
      void'(q_sclk.pop_front()); void'(q_oe.pop_front()); void'(q_sd.pop_front());
      void'(q_drv.pop_front()); void'(q_tag.pop_front());
      @(negedge clk);
    end
    start_i = 1'b0;
    sdata_i = 1'b1;
    chk("R10", "done pulse", {31'd0, done_o}, 32'd1);
    chk("R10", "busy falls", {31'd0, busy_o}, 32'd0);
    chk("R7", "sclk stopped", {31'd0, sclk_o}, 32'd0);
    chk("R7", "data released", {31'd0, sdata_oe_o}, 32'd0);
    if (last_bad >= 0) begin
      chk(last_bad == NB - 1 ? "R9" : "R7", "fail flag", {31'd0, fail_o}, 32'd1);
      chk(last_bad == NB - 1 ? "R9" : "R8", "pass flag", {31'd0, pass_o}, 32'd0);
      chk("R7", "fail index", {25'd0, fail_idx_o}, 32'(last_bad));
      chk("R7", "fail byte", {24'd0, fail_byte_o}, {24'd0, tgt[last_bad]});
    end else begin
      chk("R8", "pass flag", {31'd0, pass_o}, 32'd1);
      chk("R8", "fail flag", {31'd0, fail_o}, 32'd0);
    end
    @(negedge clk);
    chk("R10", "done one cycle", {31'd0, done_o}, 32'd0);
    chk("R10", "result held", {30'd0, pass_o, fail_o},
        (last_bad >= 0) ? 32'd1 : 32'd2);
    for (int i = 0; i < 16; i++) begin
      chk("R7", "idle no clock", {30'd0, sclk_o, sdata_oe_o}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy after reset", {31'd0, busy_o}, 32'd0);
    chk("R1", "outputs after reset",
        {26'd0, done_o, pass_o, fail_o, sclk_o, sdata_o, sdata_oe_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release",
        {25'd0, busy_o, done_o, pass_o, fail_o, sclk_o, sdata_o, sdata_oe_o}, 32'd0);
    run_case(5, 8'h10, -1);       // R7 mid-block mismatch
    run_case(-1, 8'h00, 500);     // R8 clean image, R11 stray start
    run_case(NB - 1, 8'h01, -1);  // R9 mismatch on final byte
    run_case(0, 8'h80, 40);       // R7 first byte, MSB differs
    summary();
  end

endmodule